// File: doc/BRIEF.md
# Coalescing Interrupt Source Controller

This block holds a two-bit state for each of a set of event sources. The high bit, P, means an event has been sent downstream and is waiting for its end-of-interrupt (EOI). The low bit, Q, means a further event arrived while the first one was outstanding. Because of this pair, a given source is forwarded to the downstream router at most once until software acknowledges it. Extra events fold into Q, and Q re-sends the source when the EOI arrives.

Software controls the block through a 64-bit register-access port. Loads and stores act on a source's state depending on where in that source's address window they land. Loads hand back the state as it was before the access. The window of each source is one page, or in two-page layouts a trigger half and a management half. Hardware can also raise an event through one level input per source.

Forwarded events leave as source numbers through a small FIFO with a valid/ready handshake. When the FIFO is close to full, the block pushes back on the register port and on hardware triggers, so no event is dropped.

Top module: `pq_event_source`

## Requirements
- R1: After reset every source's state is 01 (off): P is bit 1, Q is bit 0. After reset `notifValid` is low and `accReady` is high.
- R2: A trigger on state 00 moves it to 10 and forwards the source. On 10 or 11 it moves to 11 without forwarding. On 01 it leaves the state at 01 without forwarding.
- R3: An EOI on 00 or 10 moves the state to 00 without forwarding. On 11 it moves to 10 and forwards the source again. On 01 it leaves the state unchanged.
- R4: The source number is `accAddr >> PAGE_SHIFT` and the command offset is `accAddr[11:0]`. With PAGE_SHIFT of 13 or 17 the window is split: address bit PAGE_SHIFT-1 at 0 is the trigger half and at 1 the management half. With 12 or 16 the whole window acts as the management half.
- R5: On the management half, loads act by offset. 0x000–0x7FF performs an EOI and returns 1 if it forwarded, else 0. 0x800–0xBFF returns the state unchanged. 0xC00–0xFFF writes the state to offset bits [9:8] and returns the old state. Each value sits in the low bits of `rspData`.
- R6: In a split window, a load on the trigger half returns all ones, pulses `errPulse` and leaves the state unchanged.
- R7: Any store to the trigger half performs a trigger. On the management half, a store at 0x000–0x3FF performs a trigger, and a store at 0xC00–0xFFF writes the state to offset bits [9:8].
- R8: A store at 0x400–0x7FF performs an EOI when STORE_EOI is 1. When STORE_EOI is 0 it is ignored and pulses `errPulse`. A store at 0x800–0xBFF is always ignored and pulses `errPulse`.
- R9: An access whose `accSize` is not 8 bytes is illegal. Such a load returns all ones. Such a store changes nothing. Both pulse `errPulse`.
- R10: A rising edge on `trigIn[i]` performs one trigger on source i. Holding the input high or lowering it does nothing. When several edges are waiting, the lowest source number is served first, one per cycle.
- R11: When a register access and a hardware trigger hit the same source in the same cycle, the access is applied first and the trigger acts on its result.
- R12: Forwarded sources leave in order on `notifSrc`, which is held stable while `notifValid` is high and `notifReady` is low. A same-cycle access forward is queued before a trigger forward.
- R13: While the FIFO has fewer than two free entries, `accReady` is low and waiting hardware triggers are held, not lost. A load's response and every state change appear one cycle after the access is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigIn | input | NUM_SRC | Per-source hardware event level; rising edge triggers |
| accValid | input | 1 | Register access request |
| accReady | output | 1 | Access accepted this cycle when high with accValid |
| accWrite | input | 1 | 1 = store, 0 = load |
| accAddr | input | ADDR_W | Byte address inside the source windows |
| accSize | input | 4 | Access size in bytes; only 8 is legal |
| rspValid | output | 1 | Load result valid (one cycle after acceptance) |
| rspData | output | 64 | Load result as a 64-bit value, most significant byte at the lowest address |
| errPulse | output | 1 | One-cycle pulse for an illegal access |
| notifValid | output | 1 | A forwarded source is waiting |
| notifReady | input | 1 | Downstream takes the forwarded source |
| notifSrc | output | SRC_W | Number of the forwarded source |

## Verification
The embedded properties watch, on every cycle, several rules. A hardware trigger forwards only from state 00. A forward caused by an access always leaves P set. A source that is off stays off under a trigger. An illegal load always returns all ones. A waiting hardware trigger is never dropped while the FIFO is short of room. The FIFO never overflows and never changes its head while stalled. The full transition tables under every offset range, both window layouts, and the store-EOI setting can only be shown by the bench's scenarios, as can edge rather than level triggering, the access-before-trigger ordering on one source, and the in-order drain under backpressure.

// File: rtl/pqsrc_pkg.sv
package pqsrc_pkg;

  // Per-source state: bit 1 = P (sent, awaiting EOI), bit 0 = Q (more arrived)
  typedef enum logic [1:0] {
    PQ_RESET  = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_TRIG = 3'd1,
    OP_EOI  = 3'd2,
    OP_GET  = 3'd3,
    OP_SET  = 3'd4
  } op_e;

  // Strobes from the decoder to the state datapath
  typedef struct packed {
    logic       act;     // access accepted this cycle
    logic       isLoad;  // load (response expected)
    logic       bad;     // illegal access: no state change
    op_e        op;
    logic [1:0] setVal;
  } strobe_t;

  // Returns {forward, next state}
  function automatic logic [2:0] stepTrig(input pq_e cur);
    case (cur)
      PQ_RESET:          return {1'b1, PQ_PEND};
      PQ_PEND, PQ_QUEUED: return {1'b0, PQ_QUEUED};
      default:           return {1'b0, PQ_OFF};
    endcase
  endfunction

  function automatic logic [2:0] stepEoi(input pq_e cur);
    case (cur)
      PQ_RESET, PQ_PEND: return {1'b0, PQ_RESET};
      PQ_QUEUED:         return {1'b1, PQ_PEND};
      default:           return {1'b0, PQ_OFF};
    endcase
  endfunction

endpackage

// File: rtl/pqsrc_ctrl.sv
module pqsrc_ctrl
  import pqsrc_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int PAGE_SHIFT = 13,
  parameter bit STORE_EOI  = 1'b1,
  parameter int SRC_W      = 3,
  parameter int ADDR_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [3:0]         accSize,
  input  logic               roomTwo,
  output logic               accReady,
  output strobe_t            strb,
  output logic [SRC_W-1:0]   accIdx,
  output logic               trigDo,
  output logic [SRC_W-1:0]   trigIdx
);

  localparam bit TWO_PAGE = (PAGE_SHIFT == 13) || (PAGE_SHIFT == 17);

  logic [11:0]        offs;
  logic               trigHalf;
  logic [NUM_SRC-1:0] trigPrev;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clrMask;
  logic               anyPend;

  assign accReady = roomTwo;
  assign offs     = accAddr[11:0];
  assign accIdx   = accAddr[ADDR_W-1:PAGE_SHIFT];
  assign trigHalf = TWO_PAGE && !accAddr[PAGE_SHIFT-1];

  // Command decode
  always_comb begin
    strb        = '0;
    strb.op     = OP_NONE;
    strb.act    = accValid && accReady;
    strb.isLoad = !accWrite;
    if (accSize != 4'd8) begin
      strb.bad = 1'b1;
    end else if (!accWrite) begin
      if (trigHalf)              strb.bad = 1'b1;
      else if (offs < 12'h800)   strb.op  = OP_EOI;
      else if (offs < 12'hC00)   strb.op  = OP_GET;
      else begin
        strb.op     = OP_SET;
        strb.setVal = offs[9:8];
      end
    end else begin
      if (trigHalf)              strb.op = OP_TRIG;
      else if (offs < 12'h400)   strb.op = OP_TRIG;
      else if (offs < 12'h800) begin
        if (STORE_EOI) strb.op  = OP_EOI;
        else           strb.bad = 1'b1;
      end
      else if (offs < 12'hC00)   strb.bad = 1'b1;
      else begin
        strb.op     = OP_SET;
        strb.setVal = offs[9:8];
      end
    end
  end

  // Hardware trigger edges wait here; lowest index is served first
  always_comb begin
    trigIdx = '0;
    anyPend = |pend;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) trigIdx = SRC_W'(i);
    end
  end

  assign trigDo  = anyPend && roomTwo;
  assign clrMask = trigDo ? (NUM_SRC'(1) << trigIdx) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= '0;
      pend     <= '0;
    end else begin
      trigPrev <= trigIn;
      pend     <= (pend & ~clrMask) | (trigIn & ~trigPrev);
    end
  end

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (anyPend && !roomTwo) |=> pend[$past(trigIdx)]); // R13

endmodule

// File: rtl/pqsrc_dpath.sv
module pqsrc_dpath
  import pqsrc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [SRC_W-1:0] accIdx,
  input  logic             trigDo,
  input  logic [SRC_W-1:0] trigIdx,
  output logic             rspValid,
  output logic [63:0]      rspData,
  output logic             errPulse,
  output logic             push0,
  output logic [SRC_W-1:0] push0Src,
  output logic             push1,
  output logic [SRC_W-1:0] push1Src
);

  pq_e         tbl [NUM_SRC];
  pq_e         pqA, pqANew, pqT;
  logic [2:0]  resA, resT;
  logic        fwdA, mmioDo;
  logic [63:0] loadVal;

  always_comb begin
    mmioDo  = strb.act && !strb.bad;
    pqA     = tbl[accIdx];
    pqANew  = pqA;
    fwdA    = 1'b0;
    resA    = 3'b000;
    loadVal = '1;
    case (strb.op)
      OP_TRIG: resA = stepTrig(pqA);
      OP_EOI:  resA = stepEoi(pqA);
      default: resA = 3'b000;
    endcase
    if (mmioDo) begin
      case (strb.op)
        OP_TRIG, OP_EOI: begin
          fwdA   = resA[2];
          pqANew = pq_e'(resA[1:0]);
        end
        OP_SET:  pqANew = pq_e'(strb.setVal);
        default: pqANew = pqA;
      endcase
    end
    if (!strb.bad) begin
      case (strb.op)
        OP_EOI:         loadVal = {63'b0, resA[2]};
        OP_GET, OP_SET: loadVal = {62'b0, pqA};
        default:        loadVal = '1;
      endcase
    end
    // The access goes first; a trigger on the same source sees its result
    pqT  = (mmioDo && (accIdx == trigIdx)) ? pqANew : tbl[trigIdx];
    resT = stepTrig(pqT);
  end

  assign push0    = mmioDo && fwdA;
  assign push0Src = accIdx;
  assign push1    = trigDo && resT[2];
  assign push1Src = trigIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) tbl[i] <= PQ_OFF;
      rspValid <= 1'b0;
      errPulse <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.act && strb.isLoad;
      errPulse <= strb.act && strb.bad;
      if (strb.act) rspData <= loadVal;
      if (mmioDo)   tbl[accIdx]  <= pqANew;
      if (trigDo)   tbl[trigIdx] <= pq_e'(resT[1:0]);
    end
  end

  AST_FWD_LEAVES_P: assert property (@(posedge clk) disable iff (!rstN)
    push0 |=> (tbl[$past(accIdx)] == PQ_PEND || tbl[$past(accIdx)] == PQ_QUEUED)); // R3

  AST_TRIG_FWD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    push1 |-> (pqT == PQ_RESET)); // R2

  AST_OFF_STAYS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (trigDo && pqT == PQ_OFF) |=> (tbl[$past(trigIdx)] == PQ_OFF)); // R10

  AST_BAD_LOAD_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && errPulse) |-> (rspData == {64{1'b1}})); // R6

endmodule

// File: rtl/pqsrc_nfifo.sv
module pqsrc_nfifo #(
  parameter int DEPTH = 4,   // power of two, at least 2
  parameter int W     = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push0,
  input  logic [W-1:0] d0,
  input  logic         push1,
  input  logic [W-1:0] d1,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] dout,
  output logic         roomTwo
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp, wp1;
  logic [CNT_W-1:0] cnt;
  logic             pop;

  assign valid   = (cnt != '0);
  assign dout    = mem[rp];
  assign pop     = valid && ready;
  assign roomTwo = (cnt <= CNT_W'(DEPTH - 2));
  assign wp1     = push0 ? wp + PTR_W'(1) : wp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push0) mem[wp]  <= d0;
      if (push1) mem[wp1] <= d1;
      wp  <= wp + PTR_W'(push0) + PTR_W'(push1);
      if (pop) rp <= rp + PTR_W'(1);
      cnt <= cnt + CNT_W'(push0) + CNT_W'(push1) - CNT_W'(pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (push0 && push1) |-> (cnt <= CNT_W'(DEPTH - 2))); // R13

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !ready) |=> (valid && $stable(dout))); // R12

endmodule

// File: rtl/pq_event_source.sv
module pq_event_source
  import pqsrc_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int PAGE_SHIFT = 13,   // 12, 13, 16 or 17; 13 and 17 split the window
  parameter bit STORE_EOI  = 1'b1,
  parameter int FIFO_DEPTH = 4,
  localparam int SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int ADDR_W    = PAGE_SHIFT + SRC_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] trigIn,
  input  logic               accValid,
  output logic               accReady,
  input  logic               accWrite,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [3:0]         accSize,
  output logic               rspValid,
  output logic [63:0]        rspData,
  output logic               errPulse,
  output logic               notifValid,
  input  logic               notifReady,
  output logic [SRC_W-1:0]   notifSrc
);

  strobe_t          strb;
  logic [SRC_W-1:0] accIdx, trigIdx, push0Src, push1Src;
  logic             trigDo, roomTwo, push0, push1;

  pqsrc_ctrl #(
    .NUM_SRC(NUM_SRC), .PAGE_SHIFT(PAGE_SHIFT), .STORE_EOI(STORE_EOI),
    .SRC_W(SRC_W), .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn),
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr), .accSize(accSize),
    .roomTwo(roomTwo), .accReady(accReady), .strb(strb), .accIdx(accIdx),
    .trigDo(trigDo), .trigIdx(trigIdx)
  );

  pqsrc_dpath #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .accIdx(accIdx),
    .trigDo(trigDo), .trigIdx(trigIdx),
    .rspValid(rspValid), .rspData(rspData), .errPulse(errPulse),
    .push0(push0), .push0Src(push0Src), .push1(push1), .push1Src(push1Src)
  );

  pqsrc_nfifo #(.DEPTH(FIFO_DEPTH), .W(SRC_W)) uFifo (
    .clk(clk), .rstN(rstN),
    .push0(push0), .d0(push0Src), .push1(push1), .d1(push1Src),
    .ready(notifReady), .valid(notifValid), .dout(notifSrc), .roomTwo(roomTwo)
  );

endmodule

// File: tb/sim_pq_event_source.sv
module sim_pq_event_source;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  trigIn = '0;
  logic        accValid = 0, accWrite = 0, notifReady = 0;
  logic [15:0] accAddr = '0;
  logic [3:0]  accSize = 4'd8;
  logic        accReady, rspValid, errPulse, notifValid;
  logic [63:0] rspData;
  logic [2:0]  notifSrc;

  // second instance: single page, no store EOI
  logic        bValid = 0, bWrite = 0;
  logic [14:0] bAddr = '0;
  logic        bReady, bRspValid, bErr, bNotifValid;
  logic [63:0] bRspData;
  logic [2:0]  bNotifSrc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pq_event_source u0 (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .accValid(accValid), .accReady(accReady),
    .accWrite(accWrite), .accAddr(accAddr), .accSize(accSize), .rspValid(rspValid),
    .rspData(rspData), .errPulse(errPulse), .notifValid(notifValid),
    .notifReady(notifReady), .notifSrc(notifSrc)
  );

  pq_event_source #(.PAGE_SHIFT(12), .STORE_EOI(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .trigIn(8'h00), .accValid(bValid), .accReady(bReady),
    .accWrite(bWrite), .accAddr(bAddr), .accSize(4'd8), .rspValid(bRspValid),
    .rspData(bRspData), .errPulse(bErr), .notifValid(bNotifValid),
    .notifReady(1'b1), .notifSrc(bNotifSrc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] adr(input int src, input bit mgmt, input logic [11:0] off);
    return {3'(src), mgmt, off};
  endfunction

  // Called at a negedge; returns at the negedge after the accepting edge
  task automatic acc0(input bit wr, input logic [15:0] a, input logic [3:0] sz);
    accValid = 1'b1; accWrite = wr; accAddr = a; accSize = sz;
    @(posedge clk); @(negedge clk);
    accValid = 1'b0; accSize = 4'd8;
  endtask

  task automatic acc1(input bit wr, input logic [14:0] a);
    bValid = 1'b1; bWrite = wr; bAddr = a;
    @(posedge clk); @(negedge clk);
    bValid = 1'b0;
  endtask

  task automatic getPq(input int src, output logic [63:0] v);
    acc0(1'b0, adr(src, 1'b1, 12'h800), 4'd8);
    v = rspData;
  endtask

  task automatic setPq(input int src, input logic [1:0] val);
    acc0(1'b0, adr(src, 1'b1, {2'b11, val, 8'h00}), 4'd8);
  endtask

  task automatic popExpect(input string req, input int src);
    check({req, " notifValid"}, 64'(notifValid), 64'd1);
    check({req, " notifSrc"}, 64'(notifSrc), 64'(src));
    notifReady = 1'b1;
    @(posedge clk); @(negedge clk);
    notifReady = 1'b0;
  endtask

  // {wr, src[2:0], mgmt, off[11:0], expVal[7:0] (FF = all ones), expErr, expNotif, 5'b0}
  localparam int NV = 27;
  localparam logic [31:0] TBL [NV] = '{
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h01, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd0, 1'b0, 12'h000, 8'h00, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h01, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'hC00, 8'h01, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd0, 1'b0, 12'h000, 8'h00, 1'b0, 1'b1, 5'd0},
    {1'b1, 3'd0, 1'b1, 12'h000, 8'h00, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h03, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h000, 8'h01, 1'b0, 1'b1, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h7F8, 8'h00, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h00, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd0, 1'b1, 12'h400, 8'h00, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd0, 1'b1, 12'h3F8, 8'h00, 1'b0, 1'b1, 5'd0},
    {1'b1, 3'd0, 1'b1, 12'h200, 8'h00, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd0, 1'b1, 12'h400, 8'h00, 1'b0, 1'b1, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h02, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd0, 1'b1, 12'h800, 8'h00, 1'b1, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h02, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd0, 1'b1, 12'hD00, 8'h00, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h01, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b0, 12'h000, 8'hFF, 1'b1, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h000, 8'h00, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h01, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'hF00, 8'h01, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h03, 1'b0, 1'b0, 5'd0},
    {1'b1, 3'd0, 1'b1, 12'hE00, 8'h00, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd5, 1'b1, 12'h800, 8'h01, 1'b0, 1'b0, 5'd0},
    {1'b0, 3'd0, 1'b1, 12'h800, 8'h02, 1'b0, 1'b0, 5'd0}
  };

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin : main
    logic [63:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 notifValid", 64'(notifValid), 64'd0);
    check("R1 accReady", 64'(accReady), 64'd1);
    check("R1 errPulse", 64'(errPulse), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 8; s++) begin
      getPq(s, v);
      check("R1 state off", v, 64'd1);
    end

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [31:0] e;
      string tag;
      e = TBL[i];
      tag = $sformatf("R2/R3/R5/R6/R7/R8 vec%0d", i);
      acc0(e[31], {e[30:28], e[27], e[26:15]}, 4'd8);
      check({tag, " rspValid"}, 64'(rspValid), 64'(!e[31]));
      if (!e[31])
        check({tag, " data"}, rspData, (e[14:7] == 8'hFF) ? {64{1'b1}} : 64'(e[14:7]));
      check({tag, " err"}, 64'(errPulse), 64'(e[6]));
      if (e[5]) popExpect(tag, int'(e[30:28]));
      else check({tag, " no notif"}, 64'(notifValid), 64'd0);
    end

    // R9: wrong size
    acc0(1'b0, adr(1, 1'b1, 12'h800), 4'd4);
    check("R9 load ones", rspData, {64{1'b1}});
    check("R9 load err", 64'(errPulse), 64'd1);
    setPq(1, 2'b00);
    acc0(1'b1, adr(1, 1'b0, 12'h000), 4'd4);
    check("R9 store err", 64'(errPulse), 64'd1);
    check("R9 store no notif", 64'(notifValid), 64'd0);
    getPq(1, v);
    check("R9 store no change", v, 64'd0);

    // R10: edge trigger
    setPq(2, 2'b00);
    trigIn[2] = 1'b1;
    repeat (3) @(negedge clk);
    popExpect("R10 edge", 2);
    repeat (4) @(negedge clk);
    check("R10 held high no repeat", 64'(notifValid), 64'd0);
    getPq(2, v);
    check("R10 held high state", v, 64'd2);
    trigIn[2] = 1'b0;
    repeat (3) @(negedge clk);
    getPq(2, v);
    check("R10 fall no effect", v, 64'd2);
    setPq(3, 2'b00);
    setPq(6, 2'b00);
    trigIn[6] = 1'b1; trigIn[3] = 1'b1;
    repeat (4) @(negedge clk);
    popExpect("R10 lowest first", 3);
    popExpect("R10 second", 6);
    trigIn[6] = 1'b0; trigIn[3] = 1'b0;

    // R11: access applied before trigger on one source
    trigIn[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    acc0(1'b0, adr(1, 1'b1, 12'hD00), 4'd8);
    check("R11 old state", rspData, 64'd0);
    repeat (2) @(negedge clk);
    check("R11 no notif", 64'(notifValid), 64'd0);
    getPq(1, v);
    check("R11 final off", v, 64'd1);
    trigIn[1] = 1'b0;

    // R12: same-cycle access forward queued before trigger forward
    setPq(4, 2'b11);
    setPq(7, 2'b00);
    trigIn[7] = 1'b1;
    @(posedge clk); @(negedge clk);
    acc0(1'b0, adr(4, 1'b1, 12'h000), 4'd8);
    check("R12 eoi forwarded", rspData, 64'd1);
    popExpect("R12 access first", 4);
    popExpect("R12 trigger second", 7);
    trigIn[7] = 1'b0;

    // R13: backpressure
    for (int s = 0; s < 4; s++) setPq(s, 2'b00);
    acc0(1'b1, adr(0, 1'b0, 12'h000), 4'd8);
    acc0(1'b1, adr(1, 1'b0, 12'h000), 4'd8);
    check("R13 ready with two free", 64'(accReady), 64'd1);
    acc0(1'b1, adr(2, 1'b0, 12'h000), 4'd8);
    check("R13 not ready with one free", 64'(accReady), 64'd0);
    trigIn[3] = 1'b1;
    repeat (3) @(negedge clk);
    check("R13 still not ready", 64'(accReady), 64'd0);
    popExpect("R13 drain", 0);
    @(negedge clk);
    check("R13 held trigger served", 64'(accReady), 64'd0);
    popExpect("R13 drain", 1);
    popExpect("R13 drain", 2);
    popExpect("R13 held trigger", 3);
    check("R13 empty", 64'(notifValid), 64'd0);
    check("R13 ready again", 64'(accReady), 64'd1);
    trigIn[3] = 1'b0;

    // R4 / R8 on the single-page instance without store EOI
    acc1(1'b0, {3'd2, 12'h800});
    check("R4 single page get", bRspData, 64'd1);
    acc1(1'b0, {3'd2, 12'hC00});
    check("R4 single page set old", bRspData, 64'd1);
    acc1(1'b1, {3'd2, 12'h000});
    check("R4 single page trigger notif", 64'(bNotifValid), 64'd1);
    check("R4 single page notif src", 64'(bNotifSrc), 64'd2);
    acc1(1'b1, {3'd2, 12'h400});
    check("R8 store eoi disabled err", 64'(bErr), 64'd1);
    acc1(1'b0, {3'd2, 12'h800});
    check("R8 store eoi disabled no change", bRspData, 64'd2);
    acc1(1'b0, {3'd2, 12'h000});
    check("R4 single page load eoi legal", 64'(bErr), 64'd0);
    check("R4 single page load eoi value", bRspData, 64'd0);
    acc1(1'b0, {3'd2, 12'h800});
    check("R3 eoi from pending", bRspData, 64'd0);

    finishRun();
  end

endmodule